// File: doc/BRIEF.md
# Sampling Converter Serial Port Model

This block models the digital half of a 16-bit sampling converter's serial port. It is meant for a system model or a test fixture. A host drives three lines: a convert strobe, a serial clock and a serial data input. The block answers on a serial data output, shown as a data bit plus an output-enable, in place of a tri-state pin.

A rising edge on the convert strobe starts a conversion. On that same edge the level on the data input chooses the port mode: high picks a selectable (chip-select style) port, and low picks a daisy-chain port. In chain mode the level on the serial clock at that edge turns on the busy option. In selectable mode the busy option turns on if the port is selected when the conversion finishes. A fixed count of system-clock cycles stands in for the conversion time. When the count ends, the 16-bit two's complement word on `result` is loaded and shifted out MSB first, one bit per serial-clock falling edge.

In chain mode the port behaves as a shift register between its data input and its data output, so several ports can share one return line. All three host lines are synchronised into the system clock domain first. Every edge is then detected there.

Top module: `sar_port_emu`

## Requirements
- R1: On each rising edge of `cnv`, the level of `sdi` sets the mode: 1 selects selectable mode and 0 selects chain mode. The mode does not change until the next accepted rising edge of `cnv`, whatever `sdi` does in between.
- R2: In chain mode the busy option is on exactly when `sck` is 1 at the `cnv` rising edge. With the option off, the result MSB is on `sdo_data` as soon as the conversion ends.
- R3: A conversion lasts CONV_CYCLES system clocks from the accepted `cnv` rising edge. `sdo_oe` is 0 from that edge until the conversion ends. A further `cnv` rising edge during a conversion neither restarts nor stops it.
- R4: In selectable mode without busy, the port is selected when `cnv` and `sdi` are not both 1. Once selected after the conversion, the port drives the result MSB and then the next bit on each `sck` falling edge. It releases `sdo_oe` at the 16th falling edge.
- R5: In selectable mode, returning both `cnv` and `sdi` to 1 releases `sdo_oe` at once. The port stays released until the next conversion, even if it is selected again.
- R6: In selectable mode, if the port is selected when the conversion ends, busy is on. The port then drives a 0 bit at once. The first `sck` falling edge brings the MSB, and `sdo_oe` is released at the 17th falling edge.
- R7: In chain mode, each `sck` falling edge shifts `sdi` into the register behind `sdo_data`. After the 16 result bits, the `sdi` level taken at falling edge k appears on `sdo_data` after falling edge k+15.
- R8: In chain mode with busy, `sdo_oe` is 1 after the conversion and `sdo_data` follows `sdi` (0 while `sdi` is 0). The first `sck` falling edge ends this phase without shifting, and the result MSB then appears.
- R9: In chain mode after a conversion, `cnv` and `sdi` both at 0 force `sdo_data` to 0 while `sdo_oe` stays 1.
- R10: After reset `sdo_oe` is 0 and stays 0 until a conversion has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv | input | 1 | Convert strobe; also a select line in selectable mode |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data input, mode strap and select line |
| result | input | DATA_W | Two's complement word captured when a conversion ends |
| sdo_data | output | 1 | Serial output data bit |
| sdo_oe | output | 1 | Output enable for the serial output |

## Verification
The in-line properties check the following on every cycle:
- the output turns off one cycle after a conversion starts;
- a conversion lasts exactly the configured number of cycles;
- the mode changes only at an accepted strobe edge;
- the busy bit is 0 when a selectable conversion ends with the port selected;
- the shift count never passes its limit.

Only the bench scenarios can show the following:
- the bit order and the values of whole words;
- release at the 16th or 17th falling edge and on deselect;
- the 16-edge latency of the chain;
- the busy ripple, which follows `sdi`;
- that a second strobe edge during a conversion is ignored.

// File: rtl/sar_port_emu.sv
module sar_port_emu #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] result,
  output logic              sdo_data,
  output logic              sdo_oe
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [BW-1:0] LIM_PLAIN = BW'(DATA_W);
  localparam logic [BW-1:0] LIM_BUSY  = BW'(DATA_W + 1);

  logic [SYNC_STAGES-1:0] cnv_q, sck_q, sdi_q;
  logic cnv_d, sck_d, sel_d;
  logic converting, cs_mode, busy_en, have_data, released, ripple;
  logic [CW-1:0] cnt;
  logic [BW-1:0] nfall;
  logic [DATA_W:0] sh;

  wire cnv_s     = cnv_q[SYNC_STAGES-1];
  wire sck_s     = sck_q[SYNC_STAGES-1];
  wire sdi_s     = sdi_q[SYNC_STAGES-1];
  wire cnv_rise  = cnv_s & ~cnv_d;
  wire sck_fall  = ~sck_s & sck_d;
  wire sel       = ~(cnv_s & sdi_s);
  wire chain_low = ~cnv_s & ~sdi_s;
  wire [BW-1:0] limit    = busy_en ? LIM_BUSY : LIM_PLAIN;
  wire [BW-1:0] nfall_nx = nfall + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= '0;
      sck_q <= '0;
      sdi_q <= '0;
      cnv_d <= 1'b0;
      sck_d <= 1'b0;
      sel_d <= 1'b1;
    end else begin
      cnv_q <= {cnv_q[SYNC_STAGES-2:0], cnv};
      sck_q <= {sck_q[SYNC_STAGES-2:0], sck};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], sdi};
      cnv_d <= cnv_s;
      sck_d <= sck_s;
      sel_d <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      converting <= 1'b0;
      cs_mode    <= 1'b0;
      busy_en    <= 1'b0;
      have_data  <= 1'b0;
      released   <= 1'b0;
      ripple     <= 1'b0;
      cnt        <= '0;
      nfall      <= '0;
      sh         <= '0;
    end else if (converting) begin
      if (cnt == '0) begin
        converting <= 1'b0;
        have_data  <= 1'b1;
        released   <= 1'b0;
        nfall      <= '0;
        if (cs_mode) begin
          busy_en <= sel;
          sh      <= sel ? {1'b0, result} : {result, 1'b0};
        end else begin
          sh     <= {result, 1'b0};
          ripple <= busy_en;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (cnv_rise) begin
      converting <= 1'b1;
      cnt        <= CW'(CONV_CYCLES - 1);
      cs_mode    <= sdi_s;
      busy_en    <= ~sdi_s & sck_s;
      have_data  <= 1'b0;
      released   <= 1'b0;
      ripple     <= 1'b0;
    end else if (have_data) begin
      if (cs_mode) begin
        if (sel_d & ~sel) begin
          released <= 1'b1;
        end else if (sel & ~released & sck_fall) begin
          sh    <= {sh[DATA_W-1:0], 1'b0};
          nfall <= nfall_nx;
          if (nfall_nx == limit) released <= 1'b1;
        end
      end else if (sck_fall) begin
        if (ripple) ripple <= 1'b0;
        else        sh     <= {sh[DATA_W-1:1], sdi_s, 1'b0};
      end
    end
  end

  assign sdo_oe   = have_data & ~converting & (cs_mode ? (sel & ~released) : 1'b1);
  assign sdo_data = cs_mode ? sh[DATA_W] :
                    (chain_low ? 1'b0 : (ripple ? sdi_s : sh[DATA_W]));

  logic [CW:0] conv_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          conv_age <= '0;
    else if (converting) conv_age <= conv_age + 1'b1;
    else                 conv_age <= '0;
  end

  p_start_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_rise && !converting) |=> !sdo_oe);

  p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(converting) |-> (conv_age == (CW+1)'(CONV_CYCLES)));

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_rise |=> $stable(cs_mode));

  p_busy_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(converting) && cs_mode && busy_en && sdo_oe) |-> !sdo_data);

  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    have_data |-> (nfall <= limit));

  p_chain_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_mode && have_data && !converting && !cnv_s && !sdi_s) |-> (sdo_oe && !sdo_data));
endmodule

// File: tb/sar_port_emu_tb.sv
module sar_port_emu_tb;
  localparam int CONV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [15:0] result = '0;
  logic sdo_data, sdo_oe;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sar_port_emu #(.DATA_W(16), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv(cnv), .sck(sck), .sdi(sdi),
    .result(result), .sdo_data(sdo_data), .sdo_oe(sdo_oe));

  localparam logic [31:0] VEC [4] = '{
    {16'h7FFF, 16'h7FFF}, {16'h8000, 16'h8000},
    {16'h0001, 16'h0001}, {16'hA5C3, 16'hA5C3}};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fall();
    sck = 1'b1; tick(4);
    sck = 1'b0; tick(6);
  endtask

  task automatic start(input logic s_sdi, input logic s_sck, input logic [15:0] r);
    tick(32);
    cnv = 1'b0; tick(6);
    result = r; sdi = s_sdi; sck = s_sck; tick(6);
    cnv = 1'b1; tick(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    logic [15:0] gpat;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R10 oe after reset", {31'd0, sdo_oe}, 32'd0);

    // Vector table: three-wire selectable reads, no busy
    for (int i = 0; i < 4; i++) begin
      start(1'b1, 1'b0, VEC[i][31:16]);
      tick(30);
      cnv = 1'b0; tick(6);
      got[15] = sdo_data;
      for (int b = 14; b >= 0; b--) begin
        fall();
        got[b] = sdo_data;
      end
      chk("R4 oe before 16th fall", {31'd0, sdo_oe}, 32'd1);
      fall();
      chk("R4 word MSB first", {16'd0, got}, {16'd0, VEC[i][15:0]});
      chk("R4 release at 16th fall", {31'd0, sdo_oe}, 32'd0);
      cnv = 1'b1; tick(2);
    end

    // R5: four-wire deselect via sdi
    start(1'b1, 1'b0, 16'hF00D);
    tick(30);
    chk("R4 idle while not selected", {31'd0, sdo_oe}, 32'd0);
    sdi = 1'b0; tick(6);
    chk("R4 MSB on select", {30'd0, sdo_oe, sdo_data}, 32'd3);
    fall(); fall(); fall();
    sdi = 1'b1; tick(6);
    chk("R5 release on deselect", {31'd0, sdo_oe}, 32'd0);
    sdi = 1'b0; tick(6);
    chk("R5 stays released", {31'd0, sdo_oe}, 32'd0);
    sdi = 1'b1;

    // R6 and R1: mode held while sdi drops during conversion, busy on
    start(1'b1, 1'b0, 16'hC35A);
    sdi = 1'b0;
    tick(30);
    chk("R6 R1 busy bit low", {30'd0, sdo_oe, sdo_data}, 32'd2);
    for (int b = 15; b >= 0; b--) begin
      fall();
      got[b] = sdo_data;
    end
    chk("R6 busy word", {16'd0, got}, 32'h0000C35A);
    chk("R6 oe before 17th fall", {31'd0, sdo_oe}, 32'd1);
    fall();
    chk("R6 release at 17th fall", {31'd0, sdo_oe}, 32'd0);
    sdi = 1'b1;

    // R3: conversion length and ignored second strobe edge
    tick(32);
    cnv = 1'b0; sdi = 1'b1; sck = 1'b0; result = 16'h1234; tick(6);
    cnv = 1'b1; tick(6);
    cnv = 1'b0; tick(4);
    chk("R3 hiz during conversion", {31'd0, sdo_oe}, 32'd0);
    cnv = 1'b1; tick(4);
    cnv = 1'b0; tick(11);
    chk("R3 still converting", {31'd0, sdo_oe}, 32'd0);
    tick(6);
    chk("R3 done, no restart", {30'd0, sdo_oe, sdo_data}, 32'd2);
    cnv = 1'b1; tick(2);

    // R7, R2, R9: chain without busy
    start(1'b0, 1'b0, 16'h9E21);
    tick(30);
    chk("R2 no busy, MSB at once", {30'd0, sdo_oe, sdo_data}, 32'd3);
    got[15] = sdo_data;
    for (int k = 1; k < 32; k++) begin
      sdi = (k <= 16) ? 1'(16'hB3C5 >> (16 - k)) : 1'b0;
      fall();
      if (k < 16) got[15-k] = sdo_data;
      else gpat[31-k] = sdo_data;
    end
    chk("R7 result through chain", {16'd0, got}, 32'h00009E21);
    chk("R7 sdi after 16 falls", {16'd0, gpat}, 32'h0000B3C5);
    sdi = 1'b0; tick(6);
    chk("R9 cnv high keeps data", {30'd0, sdo_oe, sdo_data}, 32'd3);
    cnv = 1'b0; tick(6);
    chk("R9 both low drive 0", {30'd0, sdo_oe, sdo_data}, 32'd2);
    cnv = 1'b1; tick(2);

    // R8, R2: chain with busy ripple
    start(1'b0, 1'b1, 16'h4D2B);
    sck = 1'b0; tick(10);
    sdi = 1'b1; tick(2);
    chk("R8 hiz while converting", {31'd0, sdo_oe}, 32'd0);
    sdi = 1'b0; tick(20);
    chk("R8 R2 wait low", {30'd0, sdo_oe, sdo_data}, 32'd2);
    sdi = 1'b1; tick(6);
    chk("R8 ripple follows sdi", {30'd0, sdo_oe, sdo_data}, 32'd3);
    fall();
    got[15] = sdo_data;
    for (int b = 14; b >= 0; b--) begin
      fall();
      got[b] = sdo_data;
    end
    chk("R8 word after busy", {16'd0, got}, 32'h00004D2B);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule